// File: doc/BRIEF.md
# Prioritized Eight-Input Interrupt Controller

This block gathers eight interrupt request lines into one global interrupt and a 3-bit code naming the most urgent request. Each line can be switched on or off, and each can be set to react to a rising edge or to a held high level. Edge requests are latched and stay pending until the host acknowledges them. Level requests are pending exactly while their input stays high.

A host reaches four registers over a single-cycle synchronous bus. One sets which lines are enabled, one sets which lines use edge sensitivity, one shows the pending requests, and the last shows the pending requests and acknowledges every pending edge request when read. The global interrupt, the vector code and its valid flag are all registered. Each changes on the clock edge that samples the input change.

Top module: `irq_prio_ctrl`

## Requirements
- R1: A synchronous active-high reset clears the enable register, the sensitivity register, the pending latch, the input history and the read data, so `irq_out`, `vec_valid`, `vec_code` and `bus_rdata` are all zero after reset.
- R2: `vec_code` gives the index of the highest-numbered pending line. Line 7 has the highest priority and line 0 the lowest.
- R3: The enable register is at offset 0, bit i for line i, and 1 means enabled. A disabled line is never pending, and a line that is disabled loses its pending state on the next edge.
- R4: The sensitivity register is at offset 1, and 1 selects edge mode. An enabled edge-mode line becomes pending on the edge that samples a 0-to-1 change of its input, and it stays pending after the input falls.
- R5: An enabled level-mode line is pending from the edge after its input goes high until the edge after it goes low. Reading the acknowledge register does not affect it.
- R6: A read at offset 3 returns the pending bits as they were before the read and clears every pending edge-mode bit. An edge that is sampled in the same cycle as that read stays pending.
- R7: A read at offset 2 returns the pending bits and has no side effect. Writes to offsets 2 and 3 are ignored.
- R8: `irq_out` and `vec_valid` are high exactly when at least one line is pending. They are updated on the same edge as the pending latch.
- R9: Read data is presented on `bus_rdata` one clock after the read is sampled and holds its value until the next read. Offsets 0 and 1 read back the last value written to them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 8 | Interrupt request lines, bit i is line i |
| bus_sel | input | 1 | Bus access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| irq_out | output | 1 | Global interrupt, high while anything is pending |
| vec_valid | output | 1 | Vector code is meaningful |
| vec_code | output | 3 | Index of the highest-priority pending line |

## Verification
On every cycle, the assertions check that disabled lines are never pending and that the global interrupt and the valid flag agree with the pending latch. They also check that the vector code points at the top pending bit, and that level-mode pending bits track the input sampled one cycle earlier. The bench scenarios cover behaviour that depends on sequences. These include edge latching that outlives its input, an acknowledge read that returns the pre-clear value while a new edge arrives in the same cycle, changing a line's mode while it is pending, ignored writes, and state after a mid-run reset.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int unsigned ADDR_W = 2;
  localparam logic [ADDR_W-1:0] OFS_ENABLE = 2'd0;
  localparam logic [ADDR_W-1:0] OFS_SENSE  = 2'd1;
  localparam logic [ADDR_W-1:0] OFS_STATUS = 2'd2;
  localparam logic [ADDR_W-1:0] OFS_ACK    = 2'd3;
endpackage

// File: rtl/irqc_regs.sv
module irqc_regs
  import irqc_pkg::*;
#(
  parameter int unsigned NUM_IRQ = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [NUM_IRQ-1:0] bus_wdata,
  input  logic [NUM_IRQ-1:0] status,
  output logic [NUM_IRQ-1:0] enable_q,
  output logic [NUM_IRQ-1:0] sense_q,
  output logic [NUM_IRQ-1:0] rdata_q,
  output logic               ack_rd
);
  logic wr_en, rd_en;

  assign wr_en  = bus_sel & bus_wr;
  assign rd_en  = bus_sel & ~bus_wr;
  assign ack_rd = rd_en & (bus_addr == OFS_ACK);

  always_ff @(posedge clk) begin
    if (rst) begin
      enable_q <= '0;
      sense_q  <= '0;
    end else if (wr_en) begin
      if (bus_addr == OFS_ENABLE) enable_q <= bus_wdata;
      if (bus_addr == OFS_SENSE)  sense_q  <= bus_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (rd_en) begin
      case (bus_addr)
        OFS_ENABLE: rdata_q <= enable_q;
        OFS_SENSE:  rdata_q <= sense_q;
        default:    rdata_q <= status;
      endcase
    end
  end
endmodule

// File: rtl/irqc_edge_detect.sv
module irqc_edge_detect #(
  parameter int unsigned NUM_IRQ = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_IRQ-1:0] lines,
  output logic [NUM_IRQ-1:0] rise
);
  logic [NUM_IRQ-1:0] hist_q;

  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst) hist_q[g] <= 1'b0;
      else     hist_q[g] <= lines[g];
    end
    assign rise[g] = lines[g] & ~hist_q[g];
  end
endmodule

// File: rtl/irqc_pend_latch.sv
module irqc_pend_latch #(
  parameter int unsigned NUM_IRQ = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_IRQ-1:0] lines,
  input  logic [NUM_IRQ-1:0] rise,
  input  logic [NUM_IRQ-1:0] enable,
  input  logic [NUM_IRQ-1:0] sense,
  input  logic               ack_rd,
  output logic [NUM_IRQ-1:0] pend_nxt,
  output logic [NUM_IRQ-1:0] pend_q
);
  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_bit
    logic edge_hold;
    // an acknowledge drops the held bit, but a fresh rise in the same cycle re-arms it
    assign edge_hold   = (pend_q[g] & ~ack_rd) | rise[g];
    assign pend_nxt[g] = enable[g] & (sense[g] ? edge_hold : lines[g]);

    always_ff @(posedge clk) begin
      if (rst) pend_q[g] <= 1'b0;
      else     pend_q[g] <= pend_nxt[g];
    end
  end
endmodule

// File: rtl/irqc_prio_enc.sv
module irqc_prio_enc #(
  parameter int unsigned NUM_IRQ = 8,
  localparam int unsigned CODE_W = $clog2(NUM_IRQ)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_IRQ-1:0] req,
  output logic [CODE_W-1:0]  code_q,
  output logic               valid_q
);
  logic [CODE_W-1:0] code_c;

  // later (higher) indices overwrite lower ones, so the top set bit wins
  always_comb begin
    code_c = '0;
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (req[i]) code_c = i[CODE_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      code_q  <= code_c;
      valid_q <= |req;
    end
  end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irqc_pkg::*;
#(
  parameter int unsigned NUM_IRQ = 8,
  localparam int unsigned CODE_W = $clog2(NUM_IRQ)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_IRQ-1:0] irq_in,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [NUM_IRQ-1:0] bus_wdata,
  output logic [NUM_IRQ-1:0] bus_rdata,
  output logic               irq_out,
  output logic               vec_valid,
  output logic [CODE_W-1:0]  vec_code
);
  logic [NUM_IRQ-1:0] enable_q, sense_q, rise, pend_nxt, pend_q;
  logic               ack_rd;
  logic               irq_q;

  irqc_regs #(.NUM_IRQ(NUM_IRQ)) u_regs (
    .clk(clk), .rst(rst),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .status(pend_q),
    .enable_q(enable_q), .sense_q(sense_q), .rdata_q(bus_rdata), .ack_rd(ack_rd)
  );

  irqc_edge_detect #(.NUM_IRQ(NUM_IRQ)) u_edge (
    .clk(clk), .rst(rst), .lines(irq_in), .rise(rise)
  );

  irqc_pend_latch #(.NUM_IRQ(NUM_IRQ)) u_pend (
    .clk(clk), .rst(rst), .lines(irq_in), .rise(rise),
    .enable(enable_q), .sense(sense_q), .ack_rd(ack_rd),
    .pend_nxt(pend_nxt), .pend_q(pend_q)
  );

  irqc_prio_enc #(.NUM_IRQ(NUM_IRQ)) u_enc (
    .clk(clk), .rst(rst), .req(pend_nxt), .code_q(vec_code), .valid_q(vec_valid)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |pend_nxt;
  end
  assign irq_out = irq_q;
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
  parameter int unsigned NUM_IRQ = 8,
  localparam int unsigned CODE_W = $clog2(NUM_IRQ)
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_IRQ-1:0] irq_in,
  input logic [NUM_IRQ-1:0] pend_q,
  input logic [NUM_IRQ-1:0] enable_q,
  input logic [NUM_IRQ-1:0] sense_q,
  input logic               irq_out,
  input logic               vec_valid,
  input logic [CODE_W-1:0]  vec_code
);
  // R3: a disabled line never shows as pending
  a_r3_disabled_idle: assert property (@(posedge clk) disable iff (rst)
    (pend_q & ~enable_q) == '0 || $changed(enable_q));

  // R8: global interrupt tracks the latch
  a_r8_irq_matches_pend: assert property (@(posedge clk) disable iff (rst)
    irq_out == (|pend_q));

  // R8: valid flag agrees with the global interrupt
  a_r8_valid_eq_irq: assert property (@(posedge clk) disable iff (rst)
    vec_valid == irq_out);

  // R2: the code names the top pending bit
  a_r2_vec_highest: assert property (@(posedge clk) disable iff (rst)
    vec_valid |-> ((pend_q >> vec_code) == 1));

  // R5: level-mode bits follow the input of the previous cycle
  a_r5_level_follows: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pend_q & ~$past(sense_q)) == $past(irq_in & enable_q & ~sense_q)));
endmodule

bind irq_prio_ctrl irqc_checker #(.NUM_IRQ(NUM_IRQ)) u_chk (
  .clk(clk), .rst(rst), .irq_in(irq_in), .pend_q(pend_q),
  .enable_q(enable_q), .sense_q(sense_q),
  .irq_out(irq_out), .vec_valid(vec_valid), .vec_code(vec_code)
);

// File: tb/tb_irq_prio_ctrl.sv
`timescale 1ns/1ps
module tb_irq_prio_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] irq_in = '0;
  logic       bus_sel = 1'b0, bus_wr = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       irq_out, vec_valid;
  logic [2:0] vec_code;
  int         n_chk = 0, n_bad = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  irq_prio_ctrl dut (
    .clk(clk), .rst(rst), .irq_in(irq_in), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_out(irq_out), .vec_valid(vec_valid), .vec_code(vec_code)
  );

  // {op(0 idle,1 wr,2 rd), addr, wdata, irq, chk_rd, exp_rd, exp_irq, exp_code}
  localparam int NV = 24;
  localparam logic [32:0] VEC [NV] = '{
    {2'd0,2'd0,8'h00,8'h00,1'b0,8'h00,1'b0,3'd0}, // R1 idle after reset
    {2'd1,2'd0,8'hFF,8'h00,1'b0,8'h00,1'b0,3'd0}, // R3 enable all
    {2'd1,2'd1,8'h0F,8'h00,1'b0,8'h00,1'b0,3'd0}, // R4 lines 0-3 edge
    {2'd0,2'd0,8'h00,8'h01,1'b0,8'h00,1'b1,3'd0}, // R4 rise line 0
    {2'd0,2'd0,8'h00,8'h00,1'b0,8'h00,1'b1,3'd0}, // R4 held after fall
    {2'd0,2'd0,8'h00,8'h20,1'b0,8'h00,1'b1,3'd5}, // R5 level line 5
    {2'd2,2'd2,8'h00,8'h20,1'b1,8'h21,1'b1,3'd5}, // R7 status read
    {2'd2,2'd3,8'h00,8'h20,1'b1,8'h21,1'b1,3'd5}, // R6 ack, level stays
    {2'd0,2'd0,8'h00,8'h00,1'b0,8'h00,1'b0,3'd0}, // R5 level drops
    {2'd0,2'd0,8'h00,8'h88,1'b0,8'h00,1'b1,3'd7}, // R2 7 over 3
    {2'd0,2'd0,8'h00,8'h08,1'b0,8'h00,1'b1,3'd3}, // R5 line 7 gone
    {2'd2,2'd3,8'h00,8'h0C,1'b1,8'h08,1'b1,3'd2}, // R6 ack + new rise line 2
    {2'd1,2'd0,8'hFB,8'h0C,1'b0,8'h00,1'b1,3'd2}, // R3 disable line 2
    {2'd0,2'd0,8'h00,8'h0C,1'b0,8'h00,1'b0,3'd0}, // R3 pending dropped
    {2'd2,2'd0,8'h00,8'h00,1'b1,8'hFB,1'b0,3'd0}, // R9 enable readback
    {2'd2,2'd1,8'h00,8'h00,1'b1,8'h0F,1'b0,3'd0}, // R9 sense readback
    {2'd1,2'd2,8'hFF,8'h00,1'b0,8'h0F,1'b0,3'd0}, // R7 write status ignored
    {2'd2,2'd2,8'h00,8'h00,1'b1,8'h00,1'b0,3'd0}, // R7 status still 0
    {2'd0,2'd0,8'h00,8'h02,1'b0,8'h00,1'b1,3'd1}, // R4 rise line 1
    {2'd0,2'd0,8'h00,8'h42,1'b0,8'h00,1'b1,3'd6}, // R2 level line 6
    {2'd1,2'd1,8'h4F,8'h42,1'b0,8'h00,1'b1,3'd6}, // R4 line 6 to edge
    {2'd0,2'd0,8'h00,8'h42,1'b0,8'h00,1'b1,3'd6}, // R4 held in edge mode
    {2'd2,2'd3,8'h00,8'h00,1'b1,8'h42,1'b0,3'd0}, // R6 ack clears edges
    {2'd0,2'd0,8'h00,8'h04,1'b0,8'h00,1'b0,3'd0}  // R3 disabled rise ignored
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic bus_do(input logic [1:0] op, input logic [1:0] a, input logic [7:0] d);
    bus_sel   = (op != 2'd0);
    bus_wr    = (op == 2'd1);
    bus_addr  = a;
    bus_wdata = d;
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 irq_out", {7'd0, irq_out}, 8'h00);
    check("R1 rdata", bus_rdata, 8'h00);

    for (int v = 0; v < NV; v++) begin
      bus_do(VEC[v][32:31], VEC[v][30:29], VEC[v][28:21]);
      irq_in = VEC[v][20:13];
      @(negedge clk);
      check($sformatf("R8 irq_out v%0d", v), {7'd0, irq_out}, {7'd0, VEC[v][3]});
      check($sformatf("R8 valid v%0d", v), {7'd0, vec_valid}, {7'd0, VEC[v][3]});
      if (VEC[v][3]) check($sformatf("R2 code v%0d", v), {5'd0, vec_code}, {5'd0, VEC[v][2:0]});
      if (VEC[v][12]) check($sformatf("R9 rdata v%0d", v), bus_rdata, VEC[v][11:4]);
    end
    bus_do(2'd0, 2'd0, 8'h00);

    // R2 sweep: all level mode, lines 0..i high, code must be i
    bus_do(2'd1, 2'd1, 8'h00); @(negedge clk);
    bus_do(2'd1, 2'd0, 8'hFF); @(negedge clk);
    bus_do(2'd0, 2'd0, 8'h00);
    for (int i = 0; i < 8; i++) begin
      irq_in = 8'((16'h2 << i) - 1);
      @(negedge clk);
      check($sformatf("R2 sweep %0d", i), {5'd0, vec_code}, 8'(i));
    end

    // R1 mid-run reset with requests pending
    rst = 1'b1;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    check("R1 irq after reset", {7'd0, irq_out}, 8'h00);
    check("R1 code after reset", {5'd0, vec_code}, 8'h00);
    check("R1 rdata after reset", bus_rdata, 8'h00);
    bus_do(2'd2, 2'd0, 8'h00); @(negedge clk);
    bus_do(2'd0, 2'd0, 8'h00);
    check("R1 enable cleared", bus_rdata, 8'h00);
    irq_in = 8'h00; @(negedge clk);
    irq_in = 8'hFF; @(negedge clk);
    check("R1 R3 all disabled", {7'd0, irq_out}, 8'h00);

    done = 1'b1;
    report();
  end
endmodule